// File: doc/BRIEF.md
# Transmit FIFO with Fill-Level Interrupt

This block buffers outgoing bytes for one serial I/O channel. The host places bytes into a small first-in first-out store and the serial shifter takes them out, oldest first. The shifter sees the head byte at all times and takes it with a one-cycle pop strobe. The usable depth follows the channel's duplex setting: four bytes in half duplex and two bytes in full duplex. A write to a full store is dropped and sets an overrun flag that stays set.

The host programs an 8-bit configuration register. It holds a 2-bit threshold code, an interrupt-mode bit and a self-clearing clear bit. The block turns the threshold code into a byte count, using a different decode for each duplex mode. It raises a single-cycle transmit interrupt when the fill count reaches that level. In the extended mode it also raises the interrupt when a pop leaves the store below a level it can no longer reach. The interrupt drives no DMA request.

Top module: `sio_txq`

## Requirements
- R1: Bytes leave in the order they were accepted, and `rd_data` always shows the oldest stored byte.
- R2: Capacity is 4 bytes when `full_duplex` is 0 and 2 bytes when it is 1. A push into a full store is dropped and sets `txq_overrun`, which stays 1 until a clear.
- R3: A configuration write with bit 7 set empties the store and resets `txq_overrun`. Bit 7 always reads back as 0.
- R4: A clear that falls in the same cycle as a push or a pop wins: the store is empty after that cycle and the pushed byte is lost.
- R5: In half duplex, the threshold code in bits 1:0 selects a level of 0, 1, 2 or 3 bytes for codes 00, 01, 10 and 11.
- R6: In full duplex, codes 00 and 10 select 0 bytes, and codes 01 and 11 select 1 byte.
- R7: With the mode bit (bit 4) at 0, `tx_irq` is high for exactly one cycle, the cycle right after a push, pop or clear that brings the fill count onto the threshold from another value.
- R8: With the mode bit at 1, `tx_irq` also pulses after each pop that leaves the fill count below the threshold.
- R9: After reset all configuration fields read 0. The readback shows the mode bit at bit 4 and the threshold code at bits 1:0, and every other bit reads 0.
- R10: A pop while the store is empty has no effect on the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_duplex | input | 1 | Channel duplex setting: 1 = full, 0 = half |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | REG_W | Configuration write data |
| cfg_rdata | output | REG_W | Configuration readback |
| wr_valid | input | 1 | Host push strobe |
| wr_data | input | DATA_W | Byte to push |
| rd_pop | input | 1 | Shifter pop strobe |
| rd_data | output | DATA_W | Oldest stored byte |
| txq_empty | output | 1 | Store is empty |
| txq_full | output | 1 | Store is at its current capacity |
| txq_level | output | $clog2(DEPTH+1) | Current fill count |
| tx_irq | output | 1 | Single-cycle transmit interrupt pulse |
| txq_overrun | output | 1 | Sticky flag for a dropped push |

## Verification
Two events can fall in the same cycle: a clear issued through the configuration register, and a host push or shifter pop. The bench drives the clear together with both strobes in one cycle. It expects a fill count of zero afterwards. It then pushes and pops one new byte to confirm that the byte from the colliding push never entered the store. Interrupt pulses are judged in the cycle right after the changing edge, and again one cycle later to confirm they have dropped.

// File: rtl/sio_txq_pkg.sv
// Package: shared types and decode helpers for the serial transmit queue.
// Assumes an 8-bit configuration register with the clear bit at 7 and the
// interrupt-mode bit at 4; the threshold code sits in bits 1:0.
package sio_txq_pkg;

    localparam int unsigned CLR_BIT  = 7;
    localparam int unsigned MODE_BIT = 4;

    typedef struct packed {
        logic       irq_mode;
        logic [1:0] thr_code;
    } txq_cfg_t;

    // Turn a threshold code into a byte count for the given duplex setting.
    function automatic int unsigned thr_level(input logic [1:0] code,
                                              input logic       full_dup);
        if (full_dup)
            return int'(code[0]);
        else
            return int'(code);
    endfunction

endpackage

// File: rtl/sio_txq_cfg.sv
// Configuration register: holds the interrupt mode and threshold code and
// produces a one-cycle clear strobe from the self-clearing bit.
// Assumes REG_W is wider than the clear bit position.
module sio_txq_cfg
    import sio_txq_pkg::*;
#(
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output txq_cfg_t         cfg,
    output logic             clr_pulse,
    output logic [REG_W-1:0] rdata
);

    // Capture the mode and threshold fields on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.irq_mode <= wdata[MODE_BIT];
            cfg.thr_code <= wdata[1:0];
        end
    end

    // The clear bit is never stored; it acts only in the cycle it is written.
    assign clr_pulse = wr_en & wdata[CLR_BIT];

    // Assemble the readback with unused bits and the clear bit at zero.
    always_comb begin
        rdata           = '0;
        rdata[MODE_BIT] = cfg.irq_mode;
        rdata[1:0]      = cfg.thr_code;
    end

    // R3
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[CLR_BIT] |=> rdata[CLR_BIT] == 1'b0);

endmodule

// File: rtl/sio_txq_store.sv
// Byte store with read/write pointers and a fill counter. Capacity is DEPTH
// in half duplex and DEPTH/2 in full duplex. Clear overrides push and pop.
// Assumes DEPTH is even and at least 2.
module sio_txq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_dup,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  next_count,
    output logic              pop_done,
    output logic              full,
    output logic              empty,
    output logic              overrun
);

    localparam logic [CNT_W-1:0] CAP_HALF = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(DEPTH / 2);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cap;
    logic              push_ok;

    // Work out the current capacity and which strobes are honoured.
    always_comb begin
        cap      = full_dup ? CAP_FULL : CAP_HALF;
        empty    = (count == '0);
        full     = (count >= cap);
        pop_done = pop && !empty && !clr;
        push_ok  = push && !clr && (!full || pop_done);
        if (clr)
            next_count = '0;
        else
            next_count = count + CNT_W'(push_ok) - CNT_W'(pop_done);
    end

    // Advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_done)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= next_count;
        end
    end

    // Write accepted bytes into storage; no reset needed on data.
    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= push_data;
    end

    // Hold the overrun flag until a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            overrun <= 1'b0;
        else if (push && !push_ok)
            overrun <= 1'b1;
    end

    assign pop_data = mem[rd_ptr];

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP_HALF);

    // R2
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !clr |=> overrun);

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push && !clr |=> count == '0);

endmodule

// File: rtl/sio_txq_irq.sv
// Interrupt generator: decodes the threshold for the duplex mode and emits a
// registered one-cycle pulse on entry to the threshold or, in extended mode,
// on a pop that leaves the count below it. Drives no DMA request.
module sio_txq_irq
    import sio_txq_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  txq_cfg_t         cfg,
    input  logic             full_dup,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] next_count,
    input  logic             pop_done,
    output logic             irq
);

    logic [CNT_W-1:0] thr_lvl;
    logic             at_now, at_next, below_hit;

    // Decode the threshold and evaluate both trigger conditions.
    always_comb begin
        thr_lvl   = CNT_W'(thr_level(cfg.thr_code, full_dup));
        at_now    = (count == thr_lvl);
        at_next   = (next_count == thr_lvl);
        below_hit = cfg.irq_mode && pop_done && (next_count < thr_lvl);
    end

    // Register the pulse so it lines up with the updated fill count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (at_next && !at_now) || below_hit;
    end

    // R7
    level_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !$past(cfg.irq_mode) |-> count == $past(thr_lvl));

    // R8
    below_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg.irq_mode) && $past(pop_done) && (count < $past(thr_lvl)) |-> irq);

endmodule

// File: rtl/sio_txq.sv
// Top level of the serial transmit queue: configuration register, byte store
// and fill-level interrupt. Assumes the host clears the store after changing
// duplex mode; contents left from before that are not meaningful.
module sio_txq
    import sio_txq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned REG_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       full_duplex,
    input  logic                       cfg_we,
    input  logic [REG_W-1:0]           cfg_wdata,
    output logic [REG_W-1:0]           cfg_rdata,
    input  logic                       wr_valid,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_pop,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       txq_empty,
    output logic                       txq_full,
    output logic [$clog2(DEPTH+1)-1:0] txq_level,
    output logic                       tx_irq,
    output logic                       txq_overrun
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    txq_cfg_t         cfg;
    logic             clr;
    logic [CNT_W-1:0] next_count;
    logic             pop_done;

    sio_txq_cfg #(.REG_W(REG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wdata     (cfg_wdata),
        .cfg       (cfg),
        .clr_pulse (clr),
        .rdata     (cfg_rdata)
    );

    sio_txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .full_dup   (full_duplex),
        .clr        (clr),
        .push       (wr_valid),
        .push_data  (wr_data),
        .pop        (rd_pop),
        .pop_data   (rd_data),
        .count      (txq_level),
        .next_count (next_count),
        .pop_done   (pop_done),
        .full       (txq_full),
        .empty      (txq_empty),
        .overrun    (txq_overrun)
    );

    sio_txq_irq #(.CNT_W(CNT_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .full_dup   (full_duplex),
        .count      (txq_level),
        .next_count (next_count),
        .pop_done   (pop_done),
        .irq        (tx_irq)
    );

endmodule

// File: tb/sim_sio_txq.sv
`timescale 1ns/100ps
module sim_sio_txq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       full_duplex = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       txq_empty, txq_full, tx_irq, txq_overrun;
    logic [2:0] txq_level;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    bit model_ovr = 1'b0;

    always #2.5 clk = ~clk;

    sio_txq u0 (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_pop(rd_pop),
        .rd_data(rd_data), .txq_empty(txq_empty), .txq_full(txq_full),
        .txq_level(txq_level), .tx_irq(tx_irq), .txq_overrun(txq_overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock of stimulus; outputs are valid 1 ns after the edge.
    task automatic cycle(input bit p, input logic [7:0] d, input bit q,
                         input bit w, input logic [7:0] wd);
        @(negedge clk);
        wr_valid = p; wr_data = d; rd_pop = q; cfg_we = w; cfg_wdata = wd;
        @(posedge clk);
        #1;
        wr_valid = 1'b0; rd_pop = 1'b0; cfg_we = 1'b0;
    endtask

    // Driver: push a byte and record it in the scoreboard if it fits.
    task automatic push_item(input logic [7:0] d, input bit exp_irq, input string req);
        int cap = full_duplex ? 2 : 4;
        bit fits = (exp_q.size() < cap);
        cycle(1'b1, d, 1'b0, 1'b0, 8'h00);
        if (fits) exp_q.push_back(d);
        else      model_ovr = 1'b1;
        chk({req, " level"}, int'(txq_level), exp_q.size());
        chk({req, " irq"}, int'(tx_irq), int'(exp_irq));
        chk("R2 overrun", int'(txq_overrun), int'(model_ovr));
    endtask

    // Monitor: compare the head byte with the scoreboard, then pop.
    task automatic pop_item(input bit exp_irq, input string req);
        if (exp_q.size() > 0)
            chk("R1 head byte", int'(rd_data), int'(exp_q[0]));
        cycle(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
        if (exp_q.size() > 0) void'(exp_q.pop_front());
        chk({req, " level"}, int'(txq_level), exp_q.size());
        chk({req, " irq"}, int'(tx_irq), int'(exp_irq));
    endtask

    task automatic wcfg(input logic [7:0] v, input bit exp_irq);
        cycle(1'b0, 8'h00, 1'b0, 1'b1, v);
        if (v[7]) begin
            exp_q.delete();
            model_ovr = 1'b0;
        end
        chk("R3 level after cfg write", int'(txq_level), exp_q.size());
        chk("R7 irq after cfg write", int'(tx_irq), int'(exp_irq));
        chk("R9 readback", int'(cfg_rdata), int'(v & 8'h13));
    endtask

    task automatic idle_irq_low(input string req);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 8'h00);
        chk({req, " pulse ends"}, int'(tx_irq), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state
        chk("R9 rdata", int'(cfg_rdata), 0);
        chk("R9 empty", int'(txq_empty), 1);
        chk("R9 level", int'(txq_level), 0);
        chk("R9 irq", int'(tx_irq), 0);
        chk("R9 overrun", int'(txq_overrun), 0);

        // Half duplex, threshold 2 bytes (R5, R7)
        wcfg(8'h02, 1'b0);
        push_item(8'hA1, 1'b0, "R7");
        push_item(8'hB2, 1'b1, "R5");
        idle_irq_low("R7");
        push_item(8'hC3, 1'b0, "R1");
        push_item(8'hD4, 1'b0, "R2");
        push_item(8'hE5, 1'b0, "R2 drop");
        chk("R2 full", int'(txq_full), 1);
        pop_item(1'b0, "R1");
        pop_item(1'b1, "R5");
        pop_item(1'b0, "R1");
        pop_item(1'b0, "R1");
        pop_item(1'b0, "R10");
        chk("R10 empty", int'(txq_empty), 1);

        // Clear via register (R3)
        push_item(8'h11, 1'b0, "R3");
        push_item(8'h22, 1'b1, "R3");
        wcfg(8'h82, 1'b0);
        chk("R3 empty", int'(txq_empty), 1);
        chk("R3 overrun reset", int'(txq_overrun), 0);

        // Clear colliding with push and pop (R4)
        push_item(8'h33, 1'b0, "R4");
        cycle(1'b1, 8'h44, 1'b1, 1'b1, 8'h82);
        exp_q.delete();
        chk("R4 level", int'(txq_level), 0);
        chk("R4 empty", int'(txq_empty), 1);
        push_item(8'h55, 1'b0, "R4");
        chk("R4 head byte", int'(rd_data), 8'h55);
        pop_item(1'b0, "R4");

        // Half duplex codes 11 and 00 (R5)
        wcfg(8'h03, 1'b0);
        push_item(8'h01, 1'b0, "R5");
        push_item(8'h02, 1'b0, "R5");
        push_item(8'h03, 1'b1, "R5 code 11");
        wcfg(8'h83, 1'b0);
        wcfg(8'h00, 1'b0);
        push_item(8'h04, 1'b0, "R5");
        pop_item(1'b1, "R5 code 00");

        // Full duplex (R2, R6)
        full_duplex = 1'b1;
        wcfg(8'h80, 1'b0);
        push_item(8'h61, 1'b0, "R6");
        push_item(8'h62, 1'b0, "R6");
        push_item(8'h63, 1'b0, "R2 full duplex drop");
        chk("R2 full duplex full", int'(txq_full), 1);
        wcfg(8'h01, 1'b0);
        pop_item(1'b1, "R6 code 01");
        pop_item(1'b0, "R6");
        wcfg(8'h03, 1'b0);
        push_item(8'h64, 1'b1, "R6 code 11");
        wcfg(8'h02, 1'b0);
        pop_item(1'b1, "R6 code 10");

        // Extended mode versus plain mode (R8)
        full_duplex = 1'b0;
        wcfg(8'h80, 1'b0);
        wcfg(8'h13, 1'b0);
        push_item(8'h71, 1'b0, "R8");
        push_item(8'h72, 1'b0, "R8");
        pop_item(1'b1, "R8 below");
        pop_item(1'b1, "R8 below again");
        wcfg(8'h03, 1'b0);
        push_item(8'h73, 1'b0, "R8");
        push_item(8'h74, 1'b0, "R8");
        pop_item(1'b0, "R8 plain mode");
        pop_item(1'b0, "R8 plain mode");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule